// File: doc/BRIEF.md
# DMA Descriptor Queue Register Frontend

This block is the control plane of a single-channel DMA engine. A host programs one transfer descriptor through a small 32-bit register bus. The descriptor holds source and destination addresses, the two strides, the row length and row count (each written as length minus one) and a three-bit flag field. The host then commits the descriptor through the start register. On commit the block assigns a hardware transfer ID from a pool of 32. It then offers the descriptor to a downstream data mover on a valid/ready port and keeps it there until the mover takes it.

Completions come back from the mover as an ID strobe. The block records them in a 32-bit done bitmask, one bit per ID, and raises two interrupt sources. One fires when the mover accepts a descriptor and the staging slot frees. The other fires when a transfer finishes. Software can discover the supported length range by writing all-ones or zero to the row-length register and reading back the masked value.

Register reads are combinational and have no side effects. The word address map is: 0 interrupt mask, 1 interrupt pending, 2 control, 3 next ID, 4 start, 5 flags, 6 destination address, 7 source address, 8 row length, 9 row count, 10 destination stride, 11 source stride, 12 done mask, 13 active ID. Unmapped words read zero.

Top module: `dmaq_regfront`

## Requirements
- R1: After reset, the following all read zero: interrupt pending (word 1), control (word 2), next ID (word 3), start (word 4), done mask (word 12) and active ID (word 13). The interrupt mask (word 0) reads 3, which masks both sources, and `irq` is low.
- R2: The next-ID word (3) returns the ID the next committed descriptor receives. IDs are handed out in increasing order from 0 to 31 and then wrap to 0.
- R3: Writing a value with bit 0 set to word 4 commits the staged descriptor, but only while the channel is enabled and no earlier commit is still waiting. In any other case the write is ignored. Word 4 reads 1 from the commit until the mover accepts the descriptor, and 0 otherwise.
- R4: `desc_valid` is high while a committed descriptor waits, the channel is enabled and the channel is not paused. While `desc_ready` is low, `desc_valid` and `desc_id` hold steady. `desc_id` is the ID assigned at commit.
- R5: The row-length word (8) keeps only its low LEN_W bits, and its low ALIGN_W bits always read one. With the defaults, writing 0 reads back 0x7 and writing all-ones reads back 0x00FFFFFF. The row-count word (9) keeps its low YLEN_W bits, so all-ones reads back 0xFFFF. `desc_xlen` shows the same value as word 8.
- R6: The flags word (5) keeps bits 2:0 (bit 0 repeat, bit 1 last, bit 2 partial report) and presents them on `desc_flags`. Its upper bits read zero.
- R7: Pending bit 0 sets in the cycle after the mover accepts a descriptor. Pending bit 1 sets in the cycle after a completion strobe.
- R8: Writing ones to word 1 clears those pending bits. If a new event arrives in the same cycle as a clear, the event wins. `irq` is high when any pending bit has a zero in the mask word.
- R9: A completion strobe for ID n sets bit n of the done mask (word 12).
- R10: A commit that assigns ID n clears done bit n, so each completion is seen once per use of the ID.
- R11: Control bit 0 enables the channel and bit 1 pauses it. While paused, the staged descriptor is kept but not offered. Writing control with bit 0 clear discards the staged descriptor.
- R12: The active-ID word (13) reports the ID of the descriptor the mover accepted most recently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| desc_valid | output | 1 | Descriptor offered to the mover |
| desc_ready | input | 1 | Mover takes the descriptor |
| desc_id | output | 5 | Assigned transfer ID |
| desc_src | output | 32 | Source address |
| desc_dst | output | 32 | Destination address |
| desc_sstride | output | 24 | Source stride |
| desc_dstride | output | 24 | Destination stride |
| desc_xlen | output | 24 | Row length minus one |
| desc_ylen | output | 16 | Row count minus one |
| desc_flags | output | 3 | Repeat, last, partial-report flags |
| cmpl_valid | input | 1 | Completion strobe from the mover |
| cmpl_id | input | 5 | ID of the completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several behaviours on every cycle:
- the descriptor port holds steady while the mover stalls;
- each accept and each completion sets its pending bit one cycle later;
- a completion sets its done bit;
- every commit advances the ID by one and clears that ID's done bit;
- a disabled channel never offers a descriptor.

Some behaviours show only through the bench's scenarios: read-back masking of the length words, commits that are ignored while disabled or already staged, the discard on disable, pause keeping the staged work, masking of `irq`, and done bits clearing as IDs wrap past 31. The bench's behavioural model also compares `irq`, `desc_valid` and `desc_id` on every clock.

// File: rtl/dmaq_pkg.sv
package dmaq_pkg;
    typedef enum logic [3:0] {
        RG_MASK    = 4'd0,
        RG_PEND    = 4'd1,
        RG_CTRL    = 4'd2,
        RG_NEXT    = 4'd3,
        RG_START   = 4'd4,
        RG_FLAGS   = 4'd5,
        RG_DST     = 4'd6,
        RG_SRC     = 4'd7,
        RG_XLEN    = 4'd8,
        RG_YLEN    = 4'd9,
        RG_DSTRIDE = 4'd10,
        RG_SSTRIDE = 4'd11,
        RG_DONE    = 4'd12,
        RG_ACTIVE  = 4'd13
    } reg_idx_e;

    localparam int REG_AW     = 4;
    localparam int FLAG_W     = 3;
    localparam int IRQ_NSRC   = 2;
    localparam int IRQ_SOT    = 0;
    localparam int IRQ_EOT    = 1;
    localparam int CTRL_EN    = 0;
    localparam int CTRL_PAUSE = 1;
endpackage

// File: rtl/dmaq_idpool.sv
module dmaq_idpool #(
    parameter int IDS = 32,
    localparam int IW = $clog2(IDS)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           commit_i,
    input  logic           cmpl_valid_i,
    input  logic [IW-1:0]  cmpl_id_i,
    output logic [IW-1:0]  next_id_o,
    output logic [IDS-1:0] done_o
);
    typedef struct packed {
        logic [IW-1:0]  nid;
        logic [IDS-1:0] done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit_i) begin
            // reassignment forgets the previous completion of this ID
            st_d.done[st_q.nid] = 1'b0;
            st_d.nid = (st_q.nid == IW'(IDS - 1)) ? '0 : st_q.nid + 1'b1;
        end
        if (cmpl_valid_i) begin
            st_d.done[cmpl_id_i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign next_id_o = st_q.nid;
    assign done_o    = st_q.done;
endmodule

// File: rtl/dmaq_irq.sv
module dmaq_irq #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    input  logic            mask_we_i,
    input  logic [NSRC-1:0] mask_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] mask_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a fresh event outranks a simultaneous clear
        st_d.pend = (st_q.pend & ~clr_i) | set_i;
        if (mask_we_i) st_d.mask = mask_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign mask_o = st_q.mask;
    assign irq_o  = |(st_q.pend & ~st_q.mask);
endmodule

// File: rtl/dmaq_stage.sv
module dmaq_stage #(
    parameter int DW       = 32,
    parameter int AW       = 32,
    parameter int STRIDE_W = 24,
    parameter int LEN_W    = 24,
    parameter int ALIGN_W  = 3,
    parameter int YLEN_W   = 16,
    parameter int IW       = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_i,
    input  dmaq_pkg::reg_idx_e        idx_i,
    input  logic [DW-1:0]             wdata_i,
    input  logic                      accept_i,
    input  logic [IW-1:0]             next_id_i,
    output logic                      commit_o,
    output logic                      staged_o,
    output logic                      en_o,
    output logic                      pause_o,
    output logic [IW-1:0]             sid_o,
    output logic [IW-1:0]             act_o,
    output logic [AW-1:0]             src_o,
    output logic [AW-1:0]             dst_o,
    output logic [STRIDE_W-1:0]       sstride_o,
    output logic [STRIDE_W-1:0]       dstride_o,
    output logic [LEN_W-1:0]          xlen_o,
    output logic [YLEN_W-1:0]         ylen_o,
    output logic [dmaq_pkg::FLAG_W-1:0] flags_o
);
    import dmaq_pkg::*;

    localparam logic [LEN_W-1:0] ALIGN_ONES = LEN_W'((1 << ALIGN_W) - 1);

    typedef struct packed {
        logic                en;
        logic                pause;
        logic                staged;
        logic [IW-1:0]       sid;
        logic [IW-1:0]       act;
        logic [AW-1:0]       src;
        logic [AW-1:0]       dst;
        logic [STRIDE_W-1:0] ss;
        logic [STRIDE_W-1:0] ds;
        logic [LEN_W-1:0]    x;
        logic [YLEN_W-1:0]   y;
        logic [FLAG_W-1:0]   fl;
    } st_t;

    st_t  st_d, st_q;
    logic commit;

    assign commit = wr_i && (idx_i == RG_START) && wdata_i[0] && st_q.en && !st_q.staged;

    always_comb begin
        st_d = st_q;
        if (accept_i) begin
            st_d.staged = 1'b0;
            st_d.act    = st_q.sid;
        end
        if (commit) begin
            st_d.staged = 1'b1;
            st_d.sid    = next_id_i;
        end
        if (wr_i) begin
            case (idx_i)
                RG_CTRL: begin
                    st_d.en    = wdata_i[CTRL_EN];
                    st_d.pause = wdata_i[CTRL_PAUSE];
                    if (!wdata_i[CTRL_EN]) st_d.staged = 1'b0;
                end
                RG_FLAGS:   st_d.fl = wdata_i[FLAG_W-1:0];
                RG_DST:     st_d.dst = wdata_i[AW-1:0];
                RG_SRC:     st_d.src = wdata_i[AW-1:0];
                RG_XLEN:    st_d.x = wdata_i[LEN_W-1:0] | ALIGN_ONES;
                RG_YLEN:    st_d.y = wdata_i[YLEN_W-1:0];
                RG_DSTRIDE: st_d.ds = wdata_i[STRIDE_W-1:0];
                RG_SSTRIDE: st_d.ss = wdata_i[STRIDE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= '0;
            st_q.x <= ALIGN_ONES;
        end else begin
            st_q <= st_d;
        end
    end

    assign commit_o  = commit;
    assign staged_o  = st_q.staged;
    assign en_o      = st_q.en;
    assign pause_o   = st_q.pause;
    assign sid_o     = st_q.sid;
    assign act_o     = st_q.act;
    assign src_o     = st_q.src;
    assign dst_o     = st_q.dst;
    assign sstride_o = st_q.ss;
    assign dstride_o = st_q.ds;
    assign xlen_o    = st_q.x;
    assign ylen_o    = st_q.y;
    assign flags_o   = st_q.fl;
endmodule

// File: rtl/dmaq_regfront.sv
module dmaq_regfront #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 32,
    parameter int STRIDE_W = 24,
    parameter int LEN_W    = 24,
    parameter int ALIGN_W  = 3,
    parameter int YLEN_W   = 16,
    parameter int IDS      = 32,
    localparam int IW      = $clog2(IDS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_wr,
    input  logic [dmaq_pkg::REG_AW-1:0]  bus_addr,
    input  logic [DATA_W-1:0]            bus_wdata,
    output logic [DATA_W-1:0]            bus_rdata,
    output logic                         desc_valid,
    input  logic                         desc_ready,
    output logic [IW-1:0]                desc_id,
    output logic [ADDR_W-1:0]            desc_src,
    output logic [ADDR_W-1:0]            desc_dst,
    output logic [STRIDE_W-1:0]          desc_sstride,
    output logic [STRIDE_W-1:0]          desc_dstride,
    output logic [LEN_W-1:0]             desc_xlen,
    output logic [YLEN_W-1:0]            desc_ylen,
    output logic [dmaq_pkg::FLAG_W-1:0]  desc_flags,
    input  logic                         cmpl_valid,
    input  logic [IW-1:0]                cmpl_id,
    output logic                         irq
);
    import dmaq_pkg::*;

    reg_idx_e              idx;
    logic                  accept_w, commit_w, staged_w, en_w, pause_w;
    logic [IW-1:0]         next_id_w, act_w;
    logic [IDS-1:0]        done_w;
    logic [IRQ_NSRC-1:0]   pend_w, mask_w, set_w, clr_w;
    logic                  mask_we;

    assign idx      = reg_idx_e'(bus_addr);
    assign desc_valid = staged_w && en_w && !pause_w;
    assign accept_w = desc_valid && desc_ready;

    always_comb begin
        set_w = '0;
        set_w[IRQ_SOT] = accept_w;
        set_w[IRQ_EOT] = cmpl_valid;
    end
    assign clr_w   = (bus_wr && idx == RG_PEND) ? bus_wdata[IRQ_NSRC-1:0] : '0;
    assign mask_we = bus_wr && idx == RG_MASK;

    dmaq_stage #(
        .DW(DATA_W), .AW(ADDR_W), .STRIDE_W(STRIDE_W), .LEN_W(LEN_W),
        .ALIGN_W(ALIGN_W), .YLEN_W(YLEN_W), .IW(IW)
    ) u_stage (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .idx_i(idx), .wdata_i(bus_wdata),
        .accept_i(accept_w), .next_id_i(next_id_w), .commit_o(commit_w),
        .staged_o(staged_w), .en_o(en_w), .pause_o(pause_w), .sid_o(desc_id),
        .act_o(act_w), .src_o(desc_src), .dst_o(desc_dst), .sstride_o(desc_sstride),
        .dstride_o(desc_dstride), .xlen_o(desc_xlen), .ylen_o(desc_ylen),
        .flags_o(desc_flags)
    );

    dmaq_idpool #(.IDS(IDS)) u_ids (
        .clk(clk), .rst_n(rst_n), .commit_i(commit_w), .cmpl_valid_i(cmpl_valid),
        .cmpl_id_i(cmpl_id), .next_id_o(next_id_w), .done_o(done_w)
    );

    dmaq_irq #(.NSRC(IRQ_NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(set_w), .clr_i(clr_w), .mask_we_i(mask_we),
        .mask_i(bus_wdata[IRQ_NSRC-1:0]), .pend_o(pend_w), .mask_o(mask_w), .irq_o(irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (idx)
            RG_MASK:    bus_rdata = DATA_W'(mask_w);
            RG_PEND:    bus_rdata = DATA_W'(pend_w);
            RG_CTRL:    bus_rdata = DATA_W'({pause_w, en_w});
            RG_NEXT:    bus_rdata = DATA_W'(next_id_w);
            RG_START:   bus_rdata = DATA_W'(staged_w);
            RG_FLAGS:   bus_rdata = DATA_W'(desc_flags);
            RG_DST:     bus_rdata = DATA_W'(desc_dst);
            RG_SRC:     bus_rdata = DATA_W'(desc_src);
            RG_XLEN:    bus_rdata = DATA_W'(desc_xlen);
            RG_YLEN:    bus_rdata = DATA_W'(desc_ylen);
            RG_DSTRIDE: bus_rdata = DATA_W'(desc_dstride);
            RG_SSTRIDE: bus_rdata = DATA_W'(desc_sstride);
            RG_DONE:    bus_rdata = DATA_W'(done_w);
            RG_ACTIVE:  bus_rdata = DATA_W'(act_w);
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmaq_regfront_chk.sv
module dmaq_regfront_chk #(
    parameter int IDS = 32,
    localparam int IW = $clog2(IDS)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           desc_valid,
    input logic           desc_ready,
    input logic [IW-1:0]  desc_id,
    input logic           cmpl_valid,
    input logic [IW-1:0]  cmpl_id,
    input logic [1:0]     pend,
    input logic [IDS-1:0] done,
    input logic [IW-1:0]  next_id,
    input logic           commit,
    input logic           en
);
    p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && !desc_ready |=> !desc_valid || $stable(desc_id));

    p_sot_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid && desc_ready |=> pend[0]);

    p_eot_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> pend[1]);

    p_done_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmpl_valid |=> done[$past(cmpl_id)]);

    p_id_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> next_id == (($past(next_id) == IW'(IDS - 1)) ? '0 : $past(next_id) + 1'b1));

    p_reuse_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        commit && !(cmpl_valid && cmpl_id == next_id) |=> !done[$past(next_id)]);

    p_off_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !desc_valid);
endmodule

bind dmaq_regfront dmaq_regfront_chk #(.IDS(IDS)) u_chk (
    .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_id(desc_id), .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .pend(pend_w),
    .done(done_w), .next_id(next_id_w), .commit(commit_w), .en(en_w)
);

// File: tb/dmaq_regfront_bench.sv
module dmaq_regfront_bench;
    import dmaq_pkg::*;

    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [3:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        desc_valid, desc_ready = 0, cmpl_valid = 0, irq;
    logic [4:0]  desc_id, cmpl_id = 0;
    logic [31:0] desc_src, desc_dst;
    logic [23:0] desc_sstride, desc_dstride, desc_xlen;
    logic [15:0] desc_ylen;
    logic [2:0]  desc_flags;

    always #10 clk = ~clk;

    dmaq_regfront u_dmaq_regfront (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .desc_valid(desc_valid),
        .desc_ready(desc_ready), .desc_id(desc_id), .desc_src(desc_src),
        .desc_dst(desc_dst), .desc_sstride(desc_sstride), .desc_dstride(desc_dstride),
        .desc_xlen(desc_xlen), .desc_ylen(desc_ylen), .desc_flags(desc_flags),
        .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .irq(irq)
    );

    int n_chk = 0, n_fail = 0, cyc = 0, stub_delay = 4;

    // behavioural reference state
    bit [1:0]  m_mask = 2'b11, m_pend = 0;
    bit [31:0] m_done = 0;
    int        m_nid = 0, m_sid = 0, m_act = 0;
    bit        m_stage = 0, m_en = 0, m_pause = 0;
    int        q_id[$], q_due[$];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mask = 2'b11; m_pend = 0; m_done = 0; m_nid = 0; m_sid = 0;
            m_act = 0; m_stage = 0; m_en = 0; m_pause = 0;
        end else begin
            bit acc, com;
            bit [1:0] clr;
            acc = m_stage && m_en && !m_pause && desc_ready;
            com = bus_wr && bus_addr == 4 && bus_wdata[0] && m_en && !m_stage;
            clr = (bus_wr && bus_addr == 1) ? bus_wdata[1:0] : 2'b00;
            if (acc) begin
                q_id.push_back(m_sid); q_due.push_back(cyc + stub_delay);
                m_act = m_sid; m_stage = 0;
            end
            if (com) begin
                m_done[m_nid] = 0; m_sid = m_nid; m_stage = 1; m_nid = (m_nid + 1) % 32;
            end
            if (cmpl_valid) m_done[cmpl_id] = 1;
            m_pend = (m_pend & ~clr) | {cmpl_valid, acc};
            if (bus_wr && bus_addr == 0) m_mask = bus_wdata[1:0];
            if (bus_wr && bus_addr == 2) begin
                m_en = bus_wdata[0]; m_pause = bus_wdata[1];
                if (!bus_wdata[0]) m_stage = 0;
            end
        end
        cyc++;
    end

    // mover stub: completes each accepted ID after stub_delay cycles
    always @(negedge clk) begin
        if (q_due.size() > 0 && q_due[0] <= cyc) begin
            cmpl_valid <= 1; cmpl_id <= 5'(q_id.pop_front()); void'(q_due.pop_front());
        end else begin
            cmpl_valid <= 0;
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && cyc > 2) begin
            chk("R8 irq level", irq, |(m_pend & ~m_mask));
            chk("R4 desc_valid", desc_valid, m_stage && m_en && !m_pause);
            if (m_stage) chk("R4 desc_id", desc_id, m_sid);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; #2; v = bus_rdata;
    endtask

    task automatic rdc(input string req, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v); chk(req, v, exp);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rdc("R1 mask", RG_MASK, 3);   rdc("R1 pend", RG_PEND, 0);
        rdc("R1 ctrl", RG_CTRL, 0);   rdc("R1 next", RG_NEXT, 0);
        rdc("R1 start", RG_START, 0); rdc("R1 done", RG_DONE, 0);
        rdc("R1 active", RG_ACTIVE, 0); chk("R1 irq", irq, 0);
        // R3 commit while disabled is ignored
        wr(RG_START, 1);
        rdc("R3 start disabled", RG_START, 0); rdc("R3 next disabled", RG_NEXT, 0);
        wr(RG_CTRL, 1); wr(RG_MASK, 0);
        // R5 capability read-back
        wr(RG_XLEN, 0);          rdc("R5 xlen zero", RG_XLEN, 32'h7);
        wr(RG_XLEN, '1);         rdc("R5 xlen ones", RG_XLEN, 32'h00FF_FFFF);
        wr(RG_YLEN, '1);         rdc("R5 ylen ones", RG_YLEN, 32'h0000_FFFF);
        wr(RG_XLEN, 32'h3F0);    rdc("R5 xlen mixed", RG_XLEN, 32'h3F7);
        chk("R5 desc_xlen", desc_xlen, 24'h3F7);
        // R6 flags
        wr(RG_FLAGS, '1);        rdc("R6 flags ones", RG_FLAGS, 7);
        wr(RG_FLAGS, 2);         rdc("R6 flags last", RG_FLAGS, 2);
        chk("R6 desc_flags", desc_flags, 2);
        wr(RG_SRC, 32'h1000); wr(RG_DST, 32'h2000); wr(RG_YLEN, 3);
        chk("R4 desc_src", desc_src, 32'h1000);
        // R3/R4 commit with the mover stalled
        wr(RG_START, 1);
        rdc("R3 start pending", RG_START, 1); rdc("R2 next after commit", RG_NEXT, 1);
        chk("R4 valid after commit", desc_valid, 1); chk("R4 id 0", desc_id, 0);
        wr(RG_START, 1);
        rdc("R3 second commit ignored", RG_NEXT, 1);
        // R11 pause keeps staged work
        wr(RG_CTRL, 3);
        chk("R11 paused valid", desc_valid, 0); rdc("R11 paused start", RG_START, 1);
        wr(RG_CTRL, 1);
        chk("R11 resumed valid", desc_valid, 1);
        // accept and complete
        desc_ready = 1;
        repeat (2) @(negedge clk);
        rdc("R3 start freed", RG_START, 0); rdc("R12 active 0", RG_ACTIVE, 0);
        rd(RG_PEND, v); chk("R7 sot pending", v[0], 1);
        repeat (8) @(negedge clk);
        rdc("R9 done bit0", RG_DONE, 1); rdc("R7 both pending", RG_PEND, 3);
        chk("R8 irq raised", irq, 1);
        wr(RG_PEND, 1); rdc("R8 w1c sot", RG_PEND, 2);
        wr(RG_PEND, 2); rdc("R8 w1c eot", RG_PEND, 0);
        chk("R8 irq cleared", irq, 0);
        // R11 disable discards staged descriptor
        desc_ready = 0;
        wr(RG_START, 1);                rdc("R11 staged", RG_START, 1);
        wr(RG_CTRL, 0);
        rdc("R11 discarded", RG_START, 0); chk("R11 valid off", desc_valid, 0);
        wr(RG_CTRL, 1);
        rdc("R11 still empty", RG_START, 0); rdc("R2 next 2", RG_NEXT, 2);
        // R8 masking
        wr(RG_MASK, 3); desc_ready = 1;
        wr(RG_START, 1);
        repeat (10) @(negedge clk);
        rdc("R8 masked pending", RG_PEND, 3); chk("R8 masked irq", irq, 0);
        wr(RG_MASK, 0); chk("R8 unmasked irq", irq, 1);
        wr(RG_PEND, 3);
        rdc("R12 active 2", RG_ACTIVE, 2);
        // R10/R2 wrap the ID pool
        for (int k = 0; k < 40; k++) begin
            int id;
            do rd(RG_START, v); while (v != 0);
            id = m_nid;
            rdc("R2 next id", RG_NEXT, id);
            wr(RG_START, 1);
            rd(RG_DONE, v);
            chk("R10 done cleared on reuse", v[id], 0);
            chk("R4 desc_id assigned", desc_id, id);
        end
        repeat (20) @(negedge clk);
        rdc("R9 done mask", RG_DONE, m_done);
        rdc("R12 active last", RG_ACTIVE, (m_nid + 31) % 32);
        rdc("R2 wrapped next", RG_NEXT, 11);
        finish_run();
    end
endmodule